// File: doc/BRIEF.md
# Counter-Rotating Ring Bus Arbiter

This block arbitrates and carries transfers on an on-chip ring that links twelve participants. Each participant raises a request naming a destination and a 128-bit payload word. The arbiter picks one of four unidirectional rings for the request. Rings 0 and 1 move data toward higher participant numbers, and rings 2 and 3 move it toward lower ones. The arbiter always takes the direction with fewer hops. It admits a transfer only when the ring segments on that path are free, the ring's issue spacing allows a start, and both the source and the destination are idle.

An admitted transfer is a train of eight beats. The beats are injected at the source one per cycle. They advance one segment per cycle through real per-segment registers and leave at the destination's write port. A requester holds its request until it sees a one-cycle grant. Only one grant is issued per cycle across the whole ring.

Top module: `ring_arb`

## Requirements
- R1: While reset is asserted, `gnt` and `wr_valid` are all zero. Once reset is released, no grant appears without a request.
- R2: At most one bit of `gnt` is high in any cycle. When several placeable requesters wait, the grant goes round-robin, starting with the participant after the last one granted. Participant 0 is first after reset.
- R3: Let the clockwise distance be `(dst - src) mod 12`. If it is below 6, the transfer uses a rising ring (`gnt_ring` 0 or 1) and takes that many hops. If it is above 6, it uses a falling ring (`gnt_ring` 2 or 3) and takes `12 - distance` hops. The grant is combinational in the cycle it is accepted.
- R4: At a distance of exactly 6, either direction is legal. A free rising ring is preferred, and within a direction the lower ring number wins.
- R5: Grant the transfer in cycle C over h hops. Then `wr_valid[dst]` is high in cycles C+h through C+h+7, and beat k (k = 0..7) carries `payload + k` on `wr_data[dst]` with `wr_src[dst] = src`. No other port sees a beat.
- R6: A given ring starts a new transfer at most once every 3 cycles.
- R7: A ring carries up to 3 transfers at once when their hop segments are disjoint. A transfer whose segments overlap a live one on every eligible ring waits. Its path stays reserved until its last beat has been delivered, which is cycle C+h+8 for a grant in cycle C.
- R8: A participant sources at most one live transfer and sinks at most one live transfer at a time. A request that conflicts waits until the earlier transfer's reservation ends.
- R9: An unplaced request stays pending while held, and no grant is lost. The grant for a request lasts exactly one cycle.
- R10: A request whose destination equals its source, or whose destination is 12 or more, is never granted.
- R11: No path is longer than 6 hops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 12 | Per-participant request, held until granted |
| req_dst | input | 48 | Destination per participant, 4 bits each, participant n at [4n+3:4n] |
| req_data | input | 1536 | Payload word per participant, 128 bits each |
| gnt | output | 12 | One-cycle grant, at most one bit high |
| gnt_ring | output | 2 | Ring chosen for the current grant: 0,1 rising; 2,3 falling |
| wr_valid | output | 12 | Beat present on a participant's write port |
| wr_src | output | 48 | Source of the beat at each write port |
| wr_data | output | 1536 | Beat data at each write port |

## Verification
Suppose a slot releases too early or keeps a stale segment mask. The next admitted transfer then overwrites a segment register still in use, and within one to six cycles a beat reaches the wrong write port or carries the wrong `payload + k` value. If the spacing counter or a port-busy term is wrong, a grant appears in a cycle other than the exact one the rules predict. The bench pins each scenario's grant cycles to the cycle. A hop or direction error shifts the first beat's cycle at the destination, and the sweep over every source and destination pair catches that shift on the first beat.

// File: rtl/ring_arb.sv
module ring_arb #(
  parameter int N_PART    = 12,
  parameter int DATA_W    = 128,
  parameter int BEATS     = 8,
  parameter int ISSUE_GAP = 3,
  parameter int SLOTS     = 3,
  parameter int RPD       = 2,
  localparam int IW = $clog2(N_PART),
  localparam int RW = $clog2(2 * RPD)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PART-1:0]          req,
  input  logic [N_PART*IW-1:0]       req_dst,
  input  logic [N_PART*DATA_W-1:0]   req_data,
  output logic [N_PART-1:0]          gnt,
  output logic [RW-1:0]              gnt_ring,
  output logic [N_PART-1:0]          wr_valid,
  output logic [N_PART*IW-1:0]       wr_src,
  output logic [N_PART*DATA_W-1:0]   wr_data
);
  localparam int NR   = 2 * RPD;
  localparam int HALF = N_PART / 2;
  localparam int CNW  = $clog2(BEATS + N_PART);
  localparam int GW   = $clog2(ISSUE_GAP + 1);
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IW:0] NP = (IW+1)'(N_PART);
  localparam logic [IW:0] HL = (IW+1)'(HALF);

  typedef struct packed {
    logic [IW-1:0]     src;
    logic [IW-1:0]     dst;
    logic [DATA_W-1:0] dat;
  } beat_t;

  function automatic logic [N_PART-1:0] rot_mask(input logic [IW:0] sh, input logic [IW:0] len);
    logic [N_PART-1:0]   base;
    logic [2*N_PART-1:0] dbl;
    for (int k = 0; k < N_PART; k++) base[k] = (k < int'(len));
    dbl = {base, base} << sh;
    return dbl[2*N_PART-1:N_PART];
  endfunction

  // ring state
  logic          sg_v   [NR][N_PART];
  beat_t         sg_b   [NR][N_PART];
  logic          sl_act [NR][SLOTS];
  logic [IW-1:0] sl_src [NR][SLOTS];
  logic [IW-1:0] sl_dst [NR][SLOTS];
  logic [IW:0]   sl_hop [NR][SLOTS];
  logic [CNW-1:0] sl_cnt [NR][SLOTS];
  logic [N_PART-1:0] sl_msk [NR][SLOTS];
  logic [DATA_W-1:0] sl_pay [NR][SLOTS];
  logic [GW-1:0] gap [NR];
  logic [IW-1:0] lptr;

  // request decode
  logic [IW-1:0]     rq_dst  [N_PART];
  logic [DATA_W-1:0] rq_pay  [N_PART];
  logic [IW:0]       rq_dist [N_PART];
  logic [IW:0]       rq_hop  [N_PART];
  logic [N_PART-1:0] msk_cw  [N_PART];
  logic [N_PART-1:0] msk_ccw [N_PART];
  logic [N_PART-1:0] legal, can;
  logic [RW-1:0]     can_ring [N_PART];

  logic [N_PART-1:0] ch_busy [NR];
  logic [NR-1:0]     ch_ok, ch_start;
  logic [SW-1:0]     ch_free [NR];
  logic [N_PART-1:0] src_busy;
  logic [2**IW-1:0]  dst_busy;

  logic          gv;
  logic [IW-1:0] win;
  logic [RW-1:0] gring;

  logic  inj_v [NR][N_PART];
  beat_t inj_b [NR][N_PART];
  logic  nxt_v [NR][N_PART];
  beat_t nxt_b [NR][N_PART];
  logic  ej    [NR][N_PART];
  beat_t ej_b  [NR][N_PART];

  logic [NR*SLOTS*N_PART-1:0] occ_flat;

  for (genvar n = 0; n < N_PART; n++) begin : g_rq
    localparam logic [IW:0] NI = (IW+1)'(n);
    localparam logic [IW:0] NN = (IW+1)'(N_PART - n);
    logic [IW+1:0] rr;
    assign rq_dst[n]  = req_dst[n*IW +: IW];
    assign rq_pay[n]  = req_data[n*DATA_W +: DATA_W];
    assign rq_dist[n] = ({1'b0, rq_dst[n]} >= NI) ? ({1'b0, rq_dst[n]} - NI) : ({1'b0, rq_dst[n]} + NN);
    assign rq_hop[n]  = (rq_dist[n] > HL) ? (NP - rq_dist[n]) : rq_dist[n];
    assign legal[n]   = req[n] && ({1'b0, rq_dst[n]} < NP) && (rq_dst[n] != NI[IW-1:0]);
    assign msk_cw[n]  = rot_mask(NI, rq_hop[n]);
    assign rr         = {1'b0, NI} + {1'b0, NP} + (IW+2)'(1) - {1'b0, rq_hop[n]};
    assign msk_ccw[n] = rot_mask((rr >= {1'b0, NP}) ? (IW+1)'(rr - {1'b0, NP}) : rr[IW:0], rq_hop[n]);

    always_comb begin
      can[n]      = 1'b0;
      can_ring[n] = '0;
      if (legal[n] && !src_busy[n] && !dst_busy[rq_dst[n]]) begin
        for (int c = NR - 1; c >= 0; c--) begin
          if (ch_ok[c]) begin
            if (c < RPD && rq_dist[n] <= HL && (ch_busy[c] & msk_cw[n]) == '0) begin
              can[n]      = 1'b1;
              can_ring[n] = RW'(c);
            end
            if (c >= RPD && rq_dist[n] >= HL && (ch_busy[c] & msk_ccw[n]) == '0) begin
              can[n]      = 1'b1;
              can_ring[n] = RW'(c);
            end
          end
        end
      end
    end
  end

  always_comb begin
    src_busy = '0;
    dst_busy = '0;
    occ_flat = '0;
    for (int c = 0; c < NR; c++) begin
      ch_busy[c] = '0;
      ch_free[c] = '0;
      ch_ok[c]   = 1'b0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
        if (sl_act[c][s]) begin
          ch_busy[c] = ch_busy[c] | sl_msk[c][s];
          src_busy[sl_src[c][s]] = 1'b1;
          dst_busy[sl_dst[c][s]] = 1'b1;
          occ_flat[(c*SLOTS+s)*N_PART +: N_PART] = sl_msk[c][s];
        end else begin
          ch_free[c] = SW'(s);
          ch_ok[c]   = 1'b1;
        end
      end
      ch_ok[c] = ch_ok[c] && (gap[c] >= GW'(ISSUE_GAP));
    end
  end

  always_comb begin
    int idx;
    gv  = 1'b0;
    win = '0;
    for (int off = N_PART; off >= 1; off--) begin
      idx = int'(lptr) + off;
      if (idx >= N_PART) idx = idx - N_PART;
      if (can[idx]) begin
        gv  = 1'b1;
        win = IW'(idx);
      end
    end
    gv    = gv && rst_n;
    gring = can_ring[win];
    for (int n = 0; n < N_PART; n++) gnt[n] = gv && (win == IW'(n));
    for (int c = 0; c < NR; c++) ch_start[c] = gv && (gring == RW'(c));
  end

  assign gnt_ring = gring;

  always_comb begin
    for (int c = 0; c < NR; c++) begin
      for (int n = 0; n < N_PART; n++) begin
        inj_v[c][n] = 1'b0;
        inj_b[c][n] = '0;
      end
      for (int s = 0; s < SLOTS; s++) begin
        if (sl_act[c][s] && sl_cnt[c][s] < CNW'(BEATS)) begin
          inj_v[c][sl_src[c][s]] = 1'b1;
          inj_b[c][sl_src[c][s]] = '{src: sl_src[c][s], dst: sl_dst[c][s],
                                     dat: sl_pay[c][s] + DATA_W'(sl_cnt[c][s])};
        end
      end
      if (ch_start[c]) begin
        inj_v[c][win] = 1'b1;
        inj_b[c][win] = '{src: win, dst: rq_dst[win], dat: rq_pay[win]};
      end
    end
  end

  always_comb begin
    int pv;
    for (int c = 0; c < NR; c++) begin
      for (int n = 0; n < N_PART; n++) begin
        pv = (c < RPD) ? ((n + N_PART - 1) % N_PART) : ((n + 1) % N_PART);
        ej[c][n]    = sg_v[c][pv] && (sg_b[c][pv].dst == IW'(n));
        ej_b[c][n]  = sg_b[c][pv];
        nxt_v[c][n] = inj_v[c][n] || (sg_v[c][pv] && !ej[c][n]);
        nxt_b[c][n] = inj_v[c][n] ? inj_b[c][n] : sg_b[c][pv];
      end
    end
  end

  always_comb begin
    wr_valid = '0;
    wr_src   = '0;
    wr_data  = '0;
    for (int n = 0; n < N_PART; n++) begin
      for (int c = 0; c < NR; c++) begin
        if (ej[c][n]) begin
          wr_valid[n] = 1'b1;
          wr_src[n*IW +: IW]          = wr_src[n*IW +: IW] | ej_b[c][n].src;
          wr_data[n*DATA_W +: DATA_W] = wr_data[n*DATA_W +: DATA_W] | ej_b[c][n].dat;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lptr <= IW'(N_PART - 1);
      for (int c = 0; c < NR; c++) begin
        gap[c] <= GW'(ISSUE_GAP);
        for (int n = 0; n < N_PART; n++) sg_v[c][n] <= 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
          sl_act[c][s] <= 1'b0;
          sl_src[c][s] <= '0;
          sl_dst[c][s] <= '0;
          sl_hop[c][s] <= '0;
          sl_cnt[c][s] <= '0;
          sl_msk[c][s] <= '0;
          sl_pay[c][s] <= '0;
        end
      end
    end else begin
      if (gv) lptr <= win;
      for (int c = 0; c < NR; c++) begin
        if (ch_start[c]) gap[c] <= GW'(1);
        else if (gap[c] < GW'(ISSUE_GAP)) gap[c] <= gap[c] + GW'(1);
        for (int n = 0; n < N_PART; n++) begin
          sg_v[c][n] <= nxt_v[c][n];
          sg_b[c][n] <= nxt_b[c][n];
        end
        for (int s = 0; s < SLOTS; s++) begin
          if (sl_act[c][s]) begin
            if (sl_cnt[c][s] == CNW'(BEATS - 1) + CNW'(sl_hop[c][s])) sl_act[c][s] <= 1'b0;
            sl_cnt[c][s] <= sl_cnt[c][s] + CNW'(1);
          end else if (ch_start[c] && ch_free[c] == SW'(s)) begin
            sl_act[c][s] <= 1'b1;
            sl_src[c][s] <= win;
            sl_dst[c][s] <= rq_dst[win];
            sl_hop[c][s] <= rq_hop[win];
            sl_cnt[c][s] <= CNW'(1);
            sl_msk[c][s] <= (c < RPD) ? msk_cw[win] : msk_ccw[win];
            sl_pay[c][s] <= rq_pay[win];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ring_arb_chk.sv
module ring_arb_chk #(
  parameter int N_PART    = 12,
  parameter int NR        = 4,
  parameter int SLOTS     = 3,
  parameter int ISSUE_GAP = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_PART-1:0]          req,
  input logic [N_PART-1:0]          gnt,
  input logic [NR-1:0]              ch_start,
  input logic [NR*SLOTS*N_PART-1:0] occ
);
  localparam int GW = $clog2(ISSUE_GAP + 1);
  logic [GW-1:0] since [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NR; c++) since[c] <= GW'(ISSUE_GAP);
    end else begin
      for (int c = 0; c < NR; c++) begin
        if (ch_start[c]) since[c] <= GW'(1);
        else if (since[c] < GW'(ISSUE_GAP)) since[c] <= since[c] + GW'(1);
      end
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R9
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);

  for (genvar c = 0; c < NR; c++) begin : g_ch
    // R6
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[c] |-> since[c] >= GW'(ISSUE_GAP));
    for (genvar a = 0; a < SLOTS; a++) begin : g_a
      // R11
      hop_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ[(c*SLOTS+a)*N_PART +: N_PART]) <= N_PART / 2);
      for (genvar b = a + 1; b < SLOTS; b++) begin : g_b
        // R7
        path_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (occ[(c*SLOTS+a)*N_PART +: N_PART] & occ[(c*SLOTS+b)*N_PART +: N_PART]) == '0);
      end
    end
  end
endmodule

bind ring_arb ring_arb_chk #(.N_PART(N_PART), .NR(2*RPD), .SLOTS(SLOTS), .ISSUE_GAP(ISSUE_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .ch_start(ch_start), .occ(occ_flat));

// File: tb/ring_arb_tb.sv
module ring_arb_tb;
  localparam int N  = 12;
  localparam int IW = 4;
  localparam int DW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*IW-1:0] req_dst = '0;
  logic [N*DW-1:0] req_data = '0;
  logic [N-1:0]    gnt;
  logic [1:0]      gnt_ring;
  logic [N-1:0]    wr_valid;
  logic [N*IW-1:0] wr_src;
  logic [N*DW-1:0] wr_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int gcyc [N];
  int gring [N];

  always #2 clk = ~clk;

  ring_arb u_dut (.clk(clk), .rst_n(rst_n), .req(req), .req_dst(req_dst), .req_data(req_data),
                  .gnt(gnt), .gnt_ring(gnt_ring), .wr_valid(wr_valid), .wr_src(wr_src), .wr_data(wr_data));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pay_of(input int s, input int d);
    return (DW'(s) << 100) ^ (DW'(d) << 80) ^ 128'h0123_4567_89ab_cdef_ffff_ffff_ffff_fffd;
  endfunction

  task automatic set_req(input int s, input int d);
    req_dst[s*IW +: IW]  = IW'(d);
    req_data[s*DW +: DW] = pay_of(s, d);
    req[s] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int n = 0; n < N; n++) set_req(n, (n + 1) % N);
    repeat (3) @(negedge clk);
    #1;
    chk(gnt == '0, "R1 no grant in reset", DW'(gnt), 0);
    chk(wr_valid == '0, "R1 no write in reset", DW'(wr_valid), 0);
    req = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(gnt == '0 && wr_valid == '0, "R1 idle after reset", DW'({gnt, wr_valid}), 0);
    for (int n = 0; n < N; n++) begin
      gcyc[n]  = -1;
      gring[n] = -1;
    end
  endtask

  task automatic single(input int s, input int d);
    int dd, h, er;
    @(negedge clk);
    set_req(s, d);
    #1;
    if (d >= N || d == s) begin
      for (int k = 0; k < 6; k++) begin
        chk(gnt == '0 && wr_valid == '0, "R10 illegal destination not granted", DW'(gnt), 0);
        @(negedge clk);
        #1;
      end
      req[s] = 1'b0;
      return;
    end
    dd = (d - s + N) % N;
    h  = (dd <= 6) ? dd : N - dd;
    er = (dd <= 6) ? 0 : 2;
    chk(gnt == N'(1) << s, "R3 grant on idle ring", DW'(gnt), DW'(N'(1) << s));
    chk(int'(gnt_ring) == er, (dd == 6) ? "R4 tie picks rising ring" : "R3 ring direction", DW'(gnt_ring), DW'(er));
    for (int cyc = 1; cyc <= h + 9; cyc++) begin
      @(negedge clk);
      req[s] = 1'b0;
      #1;
      chk(gnt == '0, "R9 grant is one pulse", DW'(gnt), 0);
      if (cyc >= h && cyc <= h + 7) begin
        chk(wr_valid == N'(1) << d, "R5 beat valid at destination", DW'(wr_valid), DW'(N'(1) << d));
        chk(wr_data[d*DW +: DW] == pay_of(s, d) + DW'(cyc - h), "R5 beat data",
            wr_data[d*DW +: DW], pay_of(s, d) + DW'(cyc - h));
        chk(int'(wr_src[d*IW +: IW]) == s, "R5 beat source", DW'(wr_src[d*IW +: IW]), DW'(s));
      end else begin
        chk(wr_valid == '0, "R5 no beat outside train", DW'(wr_valid), 0);
      end
    end
  endtask

  task automatic run_set(input int ncyc);
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      if (cyc > 0) begin
        @(negedge clk);
        for (int n = 0; n < N; n++) if (gcyc[n] == cyc - 1) req[n] = 1'b0;
      end
      #1;
      chk($onehot0(gnt), "R2 at most one grant", DW'(gnt), 0);
      for (int n = 0; n < N; n++) begin
        if (gnt[n]) begin
          chk(gcyc[n] == -1, "R9 single grant per request", DW'(cyc), DW'(gcyc[n]));
          gcyc[n]  = cyc;
          gring[n] = int'(gnt_ring);
        end
      end
    end
    @(negedge clk);
    req = '0;
    repeat (25) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_c [N];
    do_reset();

    // R3 R5 R10 sweep over every pair
    for (int s = 0; s < N; s++) begin
      for (int d = 0; d < N; d++) single(s, d);
      single(s, N + (s % 4));
    end

    // R2 R6 R7: all neighbours at once, disjoint one-hop paths
    do_reset();
    exp_c = '{0, 1, 3, 4, 6, 7, 9, 10, 12, 13, 15, 16};
    @(negedge clk);
    for (int n = 0; n < N; n++) set_req(n, (n + 1) % N);
    run_set(22);
    for (int n = 0; n < N; n++) begin
      chk(gcyc[n] == exp_c[n], "R2 R6 round-robin grant cycle", DW'(gcyc[n]), DW'(exp_c[n]));
      chk(gring[n] == n % 2, "R7 ring per grant", DW'(gring[n]), DW'(n % 2));
    end

    // R7: overlapping paths wait for release
    do_reset();
    @(negedge clk);
    set_req(0, 3); set_req(1, 4); set_req(2, 5);
    run_set(16);
    chk(gcyc[0] == 0 && gring[0] == 0, "R7 first on ring 0", DW'(gcyc[0]), 0);
    chk(gcyc[1] == 1 && gring[1] == 1, "R7 second on ring 1", DW'(gcyc[1]), 1);
    chk(gcyc[2] == 11, "R7 overlap waits until release", DW'(gcyc[2]), 11);
    chk(gring[2] == 0, "R7 released ring reused", DW'(gring[2]), 0);

    // R4: six-hop tie falls back to falling ring when rising rings are spaced out
    do_reset();
    @(negedge clk);
    set_req(0, 6); set_req(1, 7); set_req(2, 8);
    run_set(6);
    chk(gcyc[0] == 0 && gring[0] == 0, "R4 tie first rising ring", DW'(gring[0]), 0);
    chk(gcyc[1] == 1 && gring[1] == 1, "R4 tie second rising ring", DW'(gring[1]), 1);
    chk(gcyc[2] == 2 && gring[2] == 2, "R4 tie takes falling ring", DW'(gring[2]), 2);

    // R8: shared destination
    do_reset();
    @(negedge clk);
    set_req(0, 2); set_req(4, 2);
    run_set(14);
    chk(gcyc[0] == 0 && gring[0] == 0, "R8 first sink grant", DW'(gcyc[0]), 0);
    chk(gcyc[4] == 10, "R8 second sink waits", DW'(gcyc[4]), 10);
    chk(gring[4] == 2, "R3 ten-step distance uses falling ring", DW'(gring[4]), 2);

    // R8 R9: same source re-requests at once
    do_reset();
    @(negedge clk);
    set_req(0, 1);
    #1;
    chk(gnt == N'(1), "R8 first source grant", DW'(gnt), 1);
    @(negedge clk);
    set_req(0, 5);
    for (int cyc = 1; cyc <= 10; cyc++) begin
      #1;
      if (cyc < 9) chk(gnt == '0, "R8 source busy holds request", DW'(gnt), 0);
      else if (cyc == 9) begin
        chk(gnt == N'(1), "R9 held request granted", DW'(gnt), 1);
        chk(gnt_ring == 2'd0, "R3 second grant ring", DW'(gnt_ring), 0);
        @(negedge clk);
        req[0] = 1'b0;
        continue;
      end else chk(gnt == '0, "R9 no repeat grant", DW'(gnt), 0);
      @(negedge clk);
    end
    repeat (20) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule